// File: doc/BRIEF.md
# Chained receive descriptor writeback engine

This engine moves received frames from a MAC-side byte stream into host memory. Software prepares a linked list of eight-word descriptors. Each descriptor names a buffer and a buffer size, and points to the next descriptor. The engine walks the list through a single request/acknowledge memory port. For each descriptor it fetches the first four words. It packs incoming bytes into 32-bit words and writes them to the buffer. When the frame ends, it writes a status word back into the descriptor. This status word clears the ownership bit, which hands the descriptor to software.

Each frame uses exactly one buffer. If a frame is longer than its buffer, the extra bytes are dropped and the status reports an error. If the engine meets a descriptor that software still owns, it raises a no-buffer flag and parks. It stays parked until software pulses the poll-kick input. A frame-done flag is raised when each status write is acknowledged. Through an enable, this flag drives an interrupt line.

Top module: `rxChainWriter`

## Requirements
- R1: After reset, memReq, inReady, noBufFlag, frameDoneFlag and irq are all 0, and no memory request is made while enable stays low.
- R2: When enable is first seen high, the engine fetches descriptor word 0 from byte address descBase. Word k of a descriptor lives at the descriptor address plus 4*k.
- R3: If bit 31 of a fetched word 0 is 0 (owned by software), noBufFlag is set and the engine parks. While parked it makes no memory request and holds inReady low. A one-cycle pulse on noBufClear clears noBufFlag.
- R4: While parked, a pulse on pollKick makes the engine re-fetch words 0..3 of the same descriptor.
- R5: Stored bytes are packed little-endian into 32-bit words. Frame byte i goes to bits 8*(i mod 4) of the word at the buffer address (word 2) plus 4*floor(i/4). A final partial word has zero upper bytes.
- R6: Bits 12:0 of word 1 give the buffer size in bytes. Frame bytes beyond that size are accepted from the stream but are never written to memory.
- R7: The status word written to word 0 has bit 31 = 0 and bits 29:16 = the number of bytes stored. Bit 15 is set if the error flag came with the last byte or the frame was cut short. Bits 9 and 8 (first and last segment) are both 1. All other bits are 0.
- R8: A memory request keeps its address, direction and write data unchanged until acknowledged. The status write is issued only after every buffer word of the frame has been acknowledged.
- R9: After a status write, the next descriptor fetched is the one at the address held in word 3, whatever word 1 bit 14 (the chained-mode flag) contains.
- R10: frameDoneFlag is set on the acknowledge of each status write and is cleared by a pulse on frameDoneClear. irq is frameDoneFlag gated by frameIrqEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Start walking the list from descBase |
| descBase | input | ADDR_W | Byte address of the first descriptor |
| pollKick | input | 1 | Pulse: resume a parked engine |
| noBufClear | input | 1 | Pulse: clear noBufFlag |
| frameDoneClear | input | 1 | Pulse: clear frameDoneFlag |
| frameIrqEn | input | 1 | Interrupt enable for frame completion |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the request |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request completed; read data valid this cycle |
| memRdata | input | 32 | Read data |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Byte is the last of its frame |
| inErr | input | 1 | MAC error, qualified with inLast |
| inReady | output | 1 | Engine accepts a byte this cycle |
| noBufFlag | output | 1 | Parked on a software-owned descriptor |
| frameDoneFlag | output | 1 | A frame has been written back |
| irq | output | 1 | Frame completion interrupt |

## Verification
A wrong descriptor pointer or a bad byte-lane counter does not show up at once on the stream side. It shows up at the ports as a status word or buffer word at the wrong address, or with the wrong contents. This becomes visible at the status write of the same frame, usually within a few dozen cycles. The bench therefore reads the whole buffer and the status word after every frame. It sweeps frame lengths across two buffer sizes, one of them not a multiple of four. A stuck parking state shows up as memory traffic or inReady during a stall, so the bench watches both for a window while parked.

// File: rtl/rxChainPkg.sv
package rxChainPkg;
  localparam int OWN_BIT  = 31;
  localparam int LEN_LO   = 16;
  localparam int LEN_W    = 14;
  localparam int ES_BIT   = 15;
  localparam int FS_BIT   = 9;
  localparam int LS_BIT   = 8;
  localparam int BSZ_W    = 13;
  localparam int LANES    = 4;
  localparam int LANE_CW  = $clog2(LANES) + 1;

  typedef enum logic [1:0] {SEL_DESC, SEL_DATA, SEL_STAT} memSel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_RECV, S_WRDATA, S_WRSTAT, S_SUSP
  } engState_e;

  typedef struct packed {
    logic    loadBase;
    logic    capSize;
    logic    capBuf;
    logic    capNext;
    logic    followNext;
    logic    startFrame;
    logic    takeByte;
    logic    dataDone;
    memSel_e memSel;
    logic [1:0] wordIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/rxChainCtrl.sv
module rxChainCtrl
  import rxChainPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               pollKick,
  input  logic               noBufClear,
  input  logic               frameDoneClear,
  input  logic               frameIrqEn,
  input  logic               memAck,
  input  logic               descOwn,
  input  logic               inValid,
  input  logic               inLast,
  input  logic               room,
  input  logic [LANE_CW-1:0] laneCnt,
  output ctlStrobe_t         stb,
  output logic               memReq,
  output logic               memWe,
  output logic               inReady,
  output logic               noBufFlag,
  output logic               frameDoneFlag,
  output logic               irq
);
  engState_e state, nxt;
  logic lastSeen, markLast, setNoBuf, setDone;
  logic [LANE_CW-1:0] newLane;

  always_comb begin
    stb      = '0;
    nxt      = state;
    setNoBuf = 1'b0;
    setDone  = 1'b0;
    markLast = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    inReady  = 1'b0;
    newLane  = laneCnt + LANE_CW'(room);
    case (state)
      S_IDLE: begin
        if (enable) begin
          stb.loadBase = 1'b1;
          nxt = S_RD0;
        end
      end
      S_RD0: begin
        memReq = 1'b1;
        stb.memSel = SEL_DESC;
        stb.wordIdx = 2'd0;
        if (memAck) begin
          if (descOwn) nxt = S_RD1;
          else begin
            setNoBuf = 1'b1;
            nxt = S_SUSP;
          end
        end
      end
      S_RD1: begin
        memReq = 1'b1;
        stb.memSel = SEL_DESC;
        stb.wordIdx = 2'd1;
        if (memAck) begin
          stb.capSize = 1'b1;
          nxt = S_RD2;
        end
      end
      S_RD2: begin
        memReq = 1'b1;
        stb.memSel = SEL_DESC;
        stb.wordIdx = 2'd2;
        if (memAck) begin
          stb.capBuf = 1'b1;
          nxt = S_RD3;
        end
      end
      S_RD3: begin
        memReq = 1'b1;
        stb.memSel = SEL_DESC;
        stb.wordIdx = 2'd3;
        if (memAck) begin
          stb.capNext = 1'b1;
          stb.startFrame = 1'b1;
          nxt = S_RECV;
        end
      end
      S_RECV: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.takeByte = 1'b1;
          if (inLast) begin
            markLast = 1'b1;
            nxt = (newLane != '0) ? S_WRDATA : S_WRSTAT;
          end else if (newLane == LANE_CW'(LANES)) begin
            nxt = S_WRDATA;
          end
        end
      end
      S_WRDATA: begin
        memReq = 1'b1;
        memWe = 1'b1;
        stb.memSel = SEL_DATA;
        if (memAck) begin
          stb.dataDone = 1'b1;
          nxt = lastSeen ? S_WRSTAT : S_RECV;
        end
      end
      S_WRSTAT: begin
        memReq = 1'b1;
        memWe = 1'b1;
        stb.memSel = SEL_STAT;
        if (memAck) begin
          setDone = 1'b1;
          stb.followNext = 1'b1;
          nxt = S_RD0;
        end
      end
      S_SUSP: begin
        if (pollKick) nxt = S_RD0;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= S_IDLE;
      lastSeen      <= 1'b0;
      noBufFlag     <= 1'b0;
      frameDoneFlag <= 1'b0;
    end else begin
      state <= nxt;
      if (markLast) lastSeen <= 1'b1;
      else if (setDone) lastSeen <= 1'b0;
      if (setNoBuf) noBufFlag <= 1'b1;
      else if (noBufClear) noBufFlag <= 1'b0;
      if (setDone) frameDoneFlag <= 1'b1;
      else if (frameDoneClear) frameDoneFlag <= 1'b0;
    end
  end

  assign irq = frameDoneFlag & frameIrqEn;
endmodule

// File: rtl/rxChainPath.sv
module rxChainPath
  import rxChainPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         stb,
  input  logic [ADDR_W-1:0]  descBase,
  input  logic [31:0]        memRdata,
  input  logic [7:0]         inData,
  input  logic               inErr,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [31:0]        memWdata,
  output logic [LANE_CW-1:0] laneCnt,
  output logic               room
);
  localparam int WORD_STEP = LANES;

  logic [ADDR_W-1:0] descAddr, bufAddr, nextAddr, dataPtr;
  logic [BSZ_W-1:0]  bufSize;
  logic [LEN_W-1:0]  storedLen;
  logic              trunc, macErr;
  logic [7:0]        laneByte [LANES];
  logic [31:0]       packWord, statusWord;
  logic              storeNow;

  assign room     = storedLen < LEN_W'(bufSize);
  assign storeNow = stb.takeByte & room;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN || stb.startFrame || stb.dataDone) laneByte[b] <= '0;
      else if (storeNow && laneCnt == LANE_CW'(b)) laneByte[b] <= inData;
    end
    assign packWord[8*b +: 8] = laneByte[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr  <= '0;
      bufAddr   <= '0;
      nextAddr  <= '0;
      dataPtr   <= '0;
      bufSize   <= '0;
      storedLen <= '0;
      laneCnt   <= '0;
      trunc     <= 1'b0;
      macErr    <= 1'b0;
    end else begin
      if (stb.loadBase) descAddr <= descBase;
      else if (stb.followNext) descAddr <= nextAddr;
      if (stb.capSize) bufSize <= memRdata[BSZ_W-1:0];
      if (stb.capBuf) bufAddr <= memRdata[ADDR_W-1:0];
      if (stb.capNext) nextAddr <= memRdata[ADDR_W-1:0];
      if (stb.startFrame) begin
        dataPtr   <= bufAddr;
        storedLen <= '0;
        laneCnt   <= '0;
        trunc     <= 1'b0;
        macErr    <= 1'b0;
      end else begin
        if (stb.takeByte) begin
          if (room) begin
            storedLen <= storedLen + 1'b1;
            laneCnt   <= laneCnt + 1'b1;
          end else begin
            trunc <= 1'b1;
          end
          if (inErr) macErr <= 1'b1;
        end
        if (stb.dataDone) begin
          laneCnt <= '0;
          dataPtr <= dataPtr + ADDR_W'(WORD_STEP);
        end
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[LEN_LO +: LEN_W] = storedLen;
    statusWord[ES_BIT] = trunc | macErr;
    statusWord[FS_BIT] = 1'b1;
    statusWord[LS_BIT] = 1'b1;
    statusWord[OWN_BIT] = 1'b0;
  end

  always_comb begin
    case (stb.memSel)
      SEL_DATA: begin
        memAddr  = dataPtr;
        memWdata = packWord;
      end
      SEL_STAT: begin
        memAddr  = descAddr;
        memWdata = statusWord;
      end
      default: begin
        memAddr  = descAddr + ADDR_W'({stb.wordIdx, 2'b00});
        memWdata = '0;
      end
    endcase
  end
endmodule

// File: rtl/rxChainWriter.sv
module rxChainWriter
  import rxChainPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [ADDR_W-1:0] descBase,
  input  logic              pollKick,
  input  logic              noBufClear,
  input  logic              frameDoneClear,
  input  logic              frameIrqEn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  logic              inErr,
  output logic              inReady,
  output logic              noBufFlag,
  output logic              frameDoneFlag,
  output logic              irq
);
  ctlStrobe_t         stb;
  logic               room;
  logic [LANE_CW-1:0] laneCnt;

  rxChainCtrl ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .pollKick(pollKick),
    .noBufClear(noBufClear), .frameDoneClear(frameDoneClear),
    .frameIrqEn(frameIrqEn), .memAck(memAck), .descOwn(memRdata[OWN_BIT]),
    .inValid(inValid), .inLast(inLast), .room(room), .laneCnt(laneCnt),
    .stb(stb), .memReq(memReq), .memWe(memWe), .inReady(inReady),
    .noBufFlag(noBufFlag), .frameDoneFlag(frameDoneFlag), .irq(irq)
  );

  rxChainPath #(.ADDR_W(ADDR_W)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .descBase(descBase),
    .memRdata(memRdata), .inData(inData), .inErr(inErr),
    .memAddr(memAddr), .memWdata(memWdata), .laneCnt(laneCnt), .room(room)
  );
endmodule

// File: rtl/rxChainWriter_chk.sv
module rxChainWriter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              memAck,
  input logic              inReady,
  input logic              noBufFlag,
  input logic              noBufClear,
  input logic              frameDoneFlag
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)); // R8
  AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(noBufFlag) |-> !memReq && !inReady); // R3
  AST_NOBUF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    noBufClear && !memAck |=> !noBufFlag); // R3
  AST_DONE_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDoneFlag) |-> $past(memAck && memWe)); // R10
  AST_STREAM_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !memReq); // R5
endmodule

bind rxChainWriter rxChainWriter_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/rxChainWriter_test.sv
`timescale 1ns/1ps
module rxChainWriter_test;
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, pollKick = 1'b0, noBufClear = 1'b0, frameDoneClear = 1'b0, frameIrqEn = 1'b0;
  logic [31:0] descBase = 32'h0;
  logic memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic inValid = 1'b0, inLast = 1'b0, inErr = 1'b0;
  logic [7:0] inData = 8'h0;
  logic inReady, noBufFlag, frameDoneFlag, irq;

  logic hostWe = 1'b0;
  logic [7:0] hostAddr = 8'h0;
  logic [31:0] hostData = 32'h0;

  logic [31:0] mem [0:255];
  int ackCount, waitCnt, readCount, dataWrCount, wordsBeforeStatus;
  logic [31:0] lastReadAddr, firstReadAddr;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rxChainWriter uut (
    .clk(clk), .rstN(rstN), .enable(enable), .descBase(descBase),
    .pollKick(pollKick), .noBufClear(noBufClear), .frameDoneClear(frameDoneClear),
    .frameIrqEn(frameIrqEn), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata), .inValid(inValid),
    .inData(inData), .inLast(inLast), .inErr(inErr), .inReady(inReady),
    .noBufFlag(noBufFlag), .frameDoneFlag(frameDoneFlag), .irq(irq)
  );

  // memory model with varying latency (0..2 wait cycles)
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= SENT;
      memAck <= 1'b0; memRdata <= '0; waitCnt <= 0; ackCount <= 0;
      readCount <= 0; dataWrCount <= 0; wordsBeforeStatus <= -1;
      lastReadAddr <= '1; firstReadAddr <= '1;
    end else begin
      memAck <= 1'b0;
      if (hostWe) mem[hostAddr] <= hostData;
      if (memReq && !memAck) begin
        if (waitCnt >= ackCount % 3) begin
          memAck <= 1'b1; waitCnt <= 0; ackCount <= ackCount + 1;
          if (memWe) begin
            mem[memAddr[9:2]] <= memWdata;
            if (memAddr < 32'h100) begin
              wordsBeforeStatus <= dataWrCount; dataWrCount <= 0;
            end else dataWrCount <= dataWrCount + 1;
          end else begin
            memRdata <= mem[memAddr[9:2]];
            readCount <= readCount + 1;
            lastReadAddr <= memAddr;
            if (readCount == 0) firstReadAddr <= memAddr;
          end
        end else waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); hostWe = 1'b1; hostAddr = a[9:2]; hostData = d;
    @(negedge clk); hostWe = 1'b0;
  endtask

  task automatic setDesc(input logic [31:0] a, input bit own, input int size,
                         input logic [31:0] buff, input logic [31:0] nxt);
    hostWrite(a, {own, 31'b0});
    hostWrite(a + 4, 32'h4000 | size);
    hostWrite(a + 8, buff);
    hostWrite(a + 12, nxt);
  endtask

  task automatic fillBuf(input logic [31:0] a);
    for (int j = 0; j < 16; j++) hostWrite(a + 4 * j, SENT);
  endtask

  function automatic logic [7:0] byteOf(input int n, input int k);
    return 8'(n * 37 + k * 5 + 3);
  endfunction

  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: pollKick = 1'b1; 1: noBufClear = 1'b1; default: frameDoneClear = 1'b1; endcase
    @(negedge clk);
    pollKick = 1'b0; noBufClear = 1'b0; frameDoneClear = 1'b0;
  endtask

  task automatic sendFrame(input int n, input int len, input bit err);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      inValid = 1'b1; inData = byteOf(n, k); inLast = (k == len - 1); inErr = err && (k == len - 1);
      #1;
      while (!inReady) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; inErr = 1'b0;
  endtask

  task automatic waitFlag(input int which, input string tag);
    int t = 0;
    while (((which == 0) ? !frameDoneFlag : (which == 1) ? !noBufFlag : !inReady) && t < 3000) begin
      @(negedge clk); t++;
    end
    chk(tag, (t < 3000) ? 32'd1 : 32'd0, 32'd1);
  endtask

  task automatic checkFrame(input string tag, input logic [31:0] da, input logic [31:0] ba,
                            input int n, input int len, input int size, input bit err);
    int s;
    bit es;
    logic [31:0] expw;
    s = (len < size) ? len : size;
    es = err || (len > size);
    chk({tag, " R7 status"}, mem[da[9:2]], (32'(s) << 16) | (32'(es) << 15) | 32'h300);
    chk({tag, " R8 order"}, 32'(wordsBeforeStatus), 32'((s + 3) / 4));
    for (int j = 0; j < 16; j++) begin
      if (4 * j < s) begin
        expw = '0;
        for (int b = 0; b < 4; b++)
          if (4 * j + b < s) expw[8*b +: 8] = byteOf(n, 4 * j + b);
        chk({tag, " R5 data"}, mem[ba[9:2] + 8'(j)], expw);
      end else begin
        chk({tag, " R6 untouched"}, mem[ba[9:2] + 8'(j)], SENT);
      end
    end
  endtask

  initial begin
    int rc;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 memReq", {31'b0, memReq}, 0);
    chk("R1 inReady", {31'b0, inReady}, 0);
    chk("R1 flags", {29'b0, noBufFlag, frameDoneFlag, irq}, 0);
    setDesc(32'h00, 1, 64, 32'h100, 32'h20);
    setDesc(32'h20, 1, 64, 32'h140, 32'h40);
    setDesc(32'h40, 1, 8, 32'h180, 32'h60);
    setDesc(32'h60, 0, 64, 32'h1C0, 32'h00);
    chk("R1 idle without enable", {31'b0, memReq}, 0);
    frameIrqEn = 1'b1;
    enable = 1'b1;
    waitFlag(2, "R2 reach receive");
    chk("R2 first fetch address", firstReadAddr, 32'h00);

    sendFrame(0, 10, 0);
    waitFlag(0, "R10 done f0");
    checkFrame("f0", 32'h00, 32'h100, 0, 10, 64, 0);
    chk("R10 irq on", {31'b0, irq}, 1);
    pulse(2);
    chk("R10 clear", {30'b0, frameDoneFlag, irq}, 0);

    frameIrqEn = 1'b0;
    sendFrame(1, 7, 1);
    waitFlag(0, "R10 done f1");
    checkFrame("f1 R9", 32'h20, 32'h140, 1, 7, 64, 1);
    chk("R10 irq gated", {30'b0, frameDoneFlag, irq}, 32'b10);
    pulse(2);
    frameIrqEn = 1'b1;

    sendFrame(2, 12, 0);
    waitFlag(0, "R10 done f2");
    checkFrame("f2 R6", 32'h40, 32'h180, 2, 12, 8, 0);
    pulse(2);

    waitFlag(1, "R3 park");
    rc = readCount;
    repeat (30) @(negedge clk);
    chk("R3 no request", {31'b0, memReq}, 0);
    chk("R3 no ready", {31'b0, inReady}, 0);
    chk("R3 no fetch", 32'(readCount), 32'(rc));
    chk("R9 parked on word3 target", lastReadAddr, 32'h60);
    pulse(1);
    chk("R3 flag cleared", {31'b0, noBufFlag}, 0);
    chk("R3 still parked", {31'b0, inReady}, 0);

    setDesc(32'h00, 1, 8, 32'h100, 32'h20);
    setDesc(32'h20, 1, 6, 32'h140, 32'h00);
    fillBuf(32'h100);
    fillBuf(32'h140);
    setDesc(32'h60, 1, 64, 32'h1C0, 32'h00);
    pulse(0);
    waitFlag(2, "R4 resume");
    chk("R4 refetch count", 32'(readCount), 32'(rc + 4));
    chk("R4 refetch word3", lastReadAddr, 32'h6C);
    sendFrame(3, 4, 0);
    waitFlag(0, "R10 done f3");
    checkFrame("f3 R4", 32'h60, 32'h1C0, 3, 4, 64, 0);
    pulse(2);

    for (int k = 0; k < 12; k++) begin
      logic [31:0] da, ba;
      int size;
      da = (k % 2) ? 32'h20 : 32'h00;
      ba = (k % 2) ? 32'h140 : 32'h100;
      size = (k % 2) ? 6 : 8;
      sendFrame(10 + k, k + 1, k == 4);
      waitFlag(0, "R10 done sweep");
      checkFrame("sweep R9", da, ba, 10 + k, k + 1, size, k == 4);
      pulse(2);
      fillBuf(ba);
      hostWrite(da, 32'h8000_0000);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule